// File: doc/BRIEF.md
# Event Queue Ring Producer

The block is the hardware side of an event queue. Each posted event (type, subtype and a 24-byte payload) becomes a 32-byte entry that is written into a power-of-two ring. Hand-over to software is tracked per slot by an ownership bit. The block clears that bit in the entry it writes. Software sets the bit back through the release port once it has consumed the slot. If a post reaches a slot that software still holds, that is an overflow: the event is dropped and a sticky status is raised.

Interrupts are gated by a small notification state machine with four states: idle, armed, fired and always-armed. Software drives this machine through 32-bit doorbell writes. The top byte of a doorbell write is the command and the low 24 bits address a queue. Other doorbell commands move the consumer index, and the block reports ring occupancy as producer minus consumer, taken modulo twice the ring depth.

Top module: `eq_ring_producer`

## Requirements
- R1: An accepted post writes a 256-bit entry, where byte k occupies bits 8k+7..8k. Byte 1 holds the type, byte 3 holds the subtype and bytes 4..27 hold the payload (payload byte j at entry byte 4+j). Byte 31 is 0x00, so the owner bit (bit 255) is 0, meaning software owns the slot. All other bytes are 0.
- R2: `wr_en_o` pulses in the cycle after the post edge. `wr_addr_o` is (producer index mod DEPTH) * 32, and the producer index then advances by one.
- R3: A post to a slot whose owner bit is 0 is dropped. There is no write and no interrupt, and the producer index holds. `ovf_o` goes to 1 and `status_o` to 9. Both are sticky until reset; `status_o` is 0 otherwise.
- R4: A pulse on `rel_i` returns slot `rel_slot_i` to hardware ownership, and a later post to that slot is accepted.
- R5: In the armed state, an accepted post raises `irq_o` for exactly one cycle, and the state moves to fired. In the fired state, accepted posts raise no interrupt.
- R6: Doorbell command 2 (request notification) puts the queue in the armed state.
- R7: Doorbell command 5 puts the queue in the always-armed state. There, every accepted post raises `irq_o` and the state does not change.
- R8: Doorbell command 3 puts the queue in the idle state. There, no interrupt is raised until the queue is armed again.
- R9: Doorbell command 1 increments the consumer index. Command 4 loads the consumer index with `db_arg_i` (mod 2*DEPTH). `used_o` equals producer minus consumer, mod 2*DEPTH.
- R10: A doorbell whose bits 23..0 differ from QUEUE_ID, or whose command is not 1 to 5, changes nothing.
- R11: When a post and a doorbell fall in the same cycle, the post is judged against the state held before that cycle, and the doorbell sets the next state. When a post and an increment fall in the same cycle, both indices move.
- R12: After reset, the queue is armed, both indices are 0, every slot is owned by hardware, and `irq_o`, `wr_en_o`, `ovf_o` and `status_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ev_valid_i | input | 1 | Event post strobe |
| ev_type_i | input | 8 | Event type |
| ev_sub_i | input | 8 | Event subtype |
| ev_payload_i | input | 192 | Event payload, 24 bytes |
| db_valid_i | input | 1 | Doorbell write strobe |
| db_word_i | input | 32 | Command in bits 31..24, queue number in bits 23..0 |
| db_arg_i | input | CNT_W | Consumer index value for the set command |
| rel_i | input | 1 | Slot release strobe from software |
| rel_slot_i | input | IDX_W | Slot being returned |
| wr_en_o | output | 1 | Ring write strobe |
| wr_addr_o | output | IDX_W+5 | Ring byte address |
| wr_data_o | output | 256 | Entry written |
| irq_o | output | 1 | Interrupt request pulse |
| ovf_o | output | 1 | Sticky overflow flag |
| status_o | output | 4 | Queue status code |
| used_o | output | CNT_W | Ring occupancy |

## Verification
The case that needs care is an event post that lands in the same cycle as a notification doorbell. The bench provokes it in both orders of state. First the queue is fired, and a post is issued together with a re-arm: no interrupt is expected, but the following post must interrupt. Then the queue is armed, and a post is issued together with a re-arm: that post interrupts, and the next one interrupts again. A further cycle combines a post with a consumer increment, and the bench checks that occupancy stays unchanged.

// File: rtl/eq_ring_pkg.sv
package eq_ring_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ARMED  = 2'd1,
    ST_FIRED  = 2'd2,
    ST_ALWAYS = 2'd3
  } arm_st_e;

  localparam logic [7:0] DB_INC_CI = 8'd1;
  localparam logic [7:0] DB_ARM    = 8'd2;
  localparam logic [7:0] DB_DISARM = 8'd3;
  localparam logic [7:0] DB_SET_CI = 8'd4;
  localparam logic [7:0] DB_ALWAYS = 8'd5;

  localparam logic [3:0] STS_OK  = 4'd0;
  localparam logic [3:0] STS_OVF = 4'd9;

  localparam int ENTRY_BITS   = 256;
  localparam int PAYLOAD_BITS = 192;
  localparam int QN_W         = 24;

  function automatic logic [ENTRY_BITS-1:0] build_entry(
    input logic [7:0] ty, input logic [7:0] sb, input logic [PAYLOAD_BITS-1:0] pl);
    logic [ENTRY_BITS-1:0] e;
    e           = '0;
    e[15:8]     = ty;
    e[31:24]    = sb;
    e[223:32]   = pl;
    e[255:248]  = 8'h00; // owner bit 255 = 0: software owns
    return e;
  endfunction
endpackage

// File: rtl/eq_owner_map.sv
module eq_owner_map #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             claim_i,
  input  logic [IDX_W-1:0] claim_slot_i,
  input  logic             rel_i,
  input  logic [IDX_W-1:0] rel_slot_i,
  output logic [DEPTH-1:0] hw_own_o
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     hw_own_o[g] <= 1'b1;
      else if (claim_i && claim_slot_i == IDX_W'(g))   hw_own_o[g] <= 1'b0;
      else if (rel_i && rel_slot_i == IDX_W'(g))       hw_own_o[g] <= 1'b1;
    end
  end

  p_claim_clears_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_i |=> !hw_own_o[$past(claim_slot_i)]);
  p_release_sets_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel_i && !(claim_i && claim_slot_i == rel_slot_i)) |=> hw_own_o[$past(rel_slot_i)]);
endmodule

// File: rtl/eq_index.sv
module eq_index #(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             inc_i,
  input  logic             set_i,
  input  logic [CNT_W-1:0] set_val_i,
  output logic [CNT_W-1:0] prod_o,
  output logic [CNT_W-1:0] cons_o,
  output logic [CNT_W-1:0] used_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_o <= '0;
      cons_o <= '0;
    end else begin
      if (adv_i) prod_o <= prod_o + 1'b1;
      if (set_i)      cons_o <= set_val_i;
      else if (inc_i) cons_o <= cons_o + 1'b1;
    end
  end

  assign used_o = prod_o - cons_o; // wraps mod 2*DEPTH

  p_set_ci_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> cons_o == $past(set_val_i));
  p_prod_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> prod_o == $past(prod_o) + 1'b1);
endmodule

// File: rtl/eq_arm_ctrl.sv
module eq_arm_ctrl
  import eq_ring_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic post_i,
  input  logic arm_i,
  input  logic always_i,
  input  logic disarm_i,
  output logic irq_o
);
  arm_st_e st_q, st_d;
  logic    irq_d;

  assign irq_d = post_i && (st_q == ST_ARMED || st_q == ST_ALWAYS);

  always_comb begin
    st_d = st_q;
    if (arm_i)                          st_d = ST_ARMED;
    else if (always_i)                  st_d = ST_ALWAYS;
    else if (disarm_i)                  st_d = ST_IDLE;
    else if (post_i && st_q == ST_ARMED) st_d = ST_FIRED;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_ARMED;
      irq_o <= 1'b0;
    end else begin
      st_q  <= st_d;
      irq_o <= irq_d;
    end
  end

  p_irq_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(post_i));
  p_fired_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_FIRED && post_i) |=> !irq_o);
  p_always_stays_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ALWAYS && post_i && !arm_i && !disarm_i) |=> (irq_o && st_q == ST_ALWAYS));
  p_idle_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && post_i) |=> !irq_o);
endmodule

// File: rtl/eq_ring_producer.sv
module eq_ring_producer
  import eq_ring_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int QUEUE_ID = 5,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CNT_W  = IDX_W + 1,
  localparam int ADDR_W = IDX_W + 5
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ev_valid_i,
  input  logic [7:0]              ev_type_i,
  input  logic [7:0]              ev_sub_i,
  input  logic [PAYLOAD_BITS-1:0] ev_payload_i,
  input  logic                    db_valid_i,
  input  logic [31:0]             db_word_i,
  input  logic [CNT_W-1:0]        db_arg_i,
  input  logic                    rel_i,
  input  logic [IDX_W-1:0]        rel_slot_i,
  output logic                    wr_en_o,
  output logic [ADDR_W-1:0]       wr_addr_o,
  output logic [ENTRY_BITS-1:0]   wr_data_o,
  output logic                    irq_o,
  output logic                    ovf_o,
  output logic [3:0]              status_o,
  output logic [CNT_W-1:0]        used_o
);
  logic [DEPTH-1:0] hw_own;
  logic [CNT_W-1:0] prod, cons;
  logic [IDX_W-1:0] slot;
  logic             accept, drop, db_hit;
  logic [7:0]       db_cmd;

  assign slot   = prod[IDX_W-1:0];
  assign accept = ev_valid_i && hw_own[slot];
  assign drop   = ev_valid_i && !hw_own[slot];
  assign db_cmd = db_word_i[31:24];
  assign db_hit = db_valid_i && (db_word_i[QN_W-1:0] == QN_W'(QUEUE_ID));

  eq_owner_map #(.DEPTH(DEPTH)) i_owner (
    .clk_i, .rst_ni,
    .claim_i(accept), .claim_slot_i(slot),
    .rel_i, .rel_slot_i,
    .hw_own_o(hw_own)
  );

  eq_index #(.DEPTH(DEPTH)) i_index (
    .clk_i, .rst_ni,
    .adv_i(accept),
    .inc_i(db_hit && db_cmd == DB_INC_CI),
    .set_i(db_hit && db_cmd == DB_SET_CI),
    .set_val_i(db_arg_i),
    .prod_o(prod), .cons_o(cons), .used_o
  );

  eq_arm_ctrl i_arm (
    .clk_i, .rst_ni,
    .post_i(accept),
    .arm_i(db_hit && db_cmd == DB_ARM),
    .always_i(db_hit && db_cmd == DB_ALWAYS),
    .disarm_i(db_hit && db_cmd == DB_DISARM),
    .irq_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      status_o  <= STS_OK;
    end else begin
      wr_en_o <= accept;
      if (accept) begin
        wr_addr_o <= {slot, 5'b0};
        wr_data_o <= build_entry(ev_type_i, ev_sub_i, ev_payload_i);
      end
      if (drop) status_o <= STS_OVF;
    end
  end

  assign ovf_o = (status_o == STS_OVF);

  p_drop_holds_prod_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop |=> prod == $past(prod));
  p_ovf_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);
  p_write_claims_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && !$past(rel_i)) |-> !hw_own[wr_addr_o[ADDR_W-1:5]]);
  p_owner_sw_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> !wr_data_o[ENTRY_BITS-1]);
endmodule

// File: tb/test_eq_ring_producer.sv
`timescale 1ns/1ps
module test_eq_ring_producer;
  localparam int DEPTH = 8;
  localparam int QID   = 5;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = IDX_W + 1;

  logic             clk = 0, rst_n = 0;
  logic             ev_valid = 0, db_valid = 0, rel = 0;
  logic [7:0]       ev_type = 0, ev_sub = 0;
  logic [191:0]     ev_pl = 0;
  logic [31:0]      db_word = 0;
  logic [CNT_W-1:0] db_arg = 0;
  logic [IDX_W-1:0] rel_slot = 0;
  logic             wr_en, irq, ovf;
  logic [IDX_W+4:0] wr_addr;
  logic [255:0]     wr_data;
  logic [3:0]       status;
  logic [CNT_W-1:0] used;

  int n_chk = 0, n_fail = 0, e_prod = 0;
  bit done = 0;

  always #5 clk = ~clk;

  eq_ring_producer #(.DEPTH(DEPTH), .QUEUE_ID(QID)) i_eq_ring_producer (
    .clk_i(clk), .rst_ni(rst_n),
    .ev_valid_i(ev_valid), .ev_type_i(ev_type), .ev_sub_i(ev_sub), .ev_payload_i(ev_pl),
    .db_valid_i(db_valid), .db_word_i(db_word), .db_arg_i(db_arg),
    .rel_i(rel), .rel_slot_i(rel_slot),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .irq_o(irq), .ovf_o(ovf), .status_o(status), .used_o(used)
  );

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [255:0] exp_entry(input logic [7:0] ty, input logic [7:0] sb,
                                             input logic [191:0] pl);
    logic [255:0] e = '0;
    e[8 +: 8]  = ty;
    e[24 +: 8] = sb;
    for (int k = 4; k < 28; k++) e[8*k +: 8] = pl[8*(k-4) +: 8];
    return e;
  endfunction

  // one cycle of stimulus from a negedge; outputs are sampled at the next negedge
  task automatic cyc(input bit ev, input bit db, input logic [7:0] cmd, input int qn,
                     input int arg, input bit rl, input int rs);
    ev_valid = ev; db_valid = db; db_word = {cmd, 24'(qn)}; db_arg = CNT_W'(arg);
    rel = rl; rel_slot = IDX_W'(rs);
    @(negedge clk);
    ev_valid = 0; db_valid = 0; rel = 0;
  endtask

  task automatic post(input logic [7:0] ty, input logic [7:0] sb, input logic [191:0] pl,
                      input bit exp_irq, input string tag);
    ev_type = ty; ev_sub = sb; ev_pl = pl;
    cyc(1, 0, 0, 0, 0, 0, 0);
    chk({tag, " wr_en"}, 256'(wr_en), 256'(1));
    chk({tag, " addr R2"}, 256'(wr_addr), 256'((e_prod % DEPTH) * 32));
    chk({tag, " irq"}, 256'(irq), 256'(exp_irq));
    e_prod++;
  endtask

  task automatic db(input logic [7:0] cmd, input int qn, input int arg);
    cyc(0, 1, cmd, qn, arg, 0, 0);
  endtask

  task automatic release_all_sync();
    for (int s = 0; s < DEPTH; s++) cyc(0, 0, 0, 0, 0, 1, s);
    db(8'd4, QID, e_prod);
    chk("R9 set ci to prod", 256'(used), 256'(0));
  endtask

  task automatic t_reset();
    chk("R12 irq", 256'(irq), 0);
    chk("R12 wr_en", 256'(wr_en), 0);
    chk("R12 ovf", 256'(ovf), 0);
    chk("R12 status", 256'(status), 0);
    chk("R12 used", 256'(used), 0);
  endtask

  task automatic t_entry_and_arm();
    logic [191:0] p1 = {6{32'hA5C3_1E70}} ^ 192'h0123_4567_89AB_CDEF;
    post(8'h0A, 8'h04, p1, 1, "R12 R5 first post armed");
    chk("R1 entry", wr_data, exp_entry(8'h0A, 8'h04, p1));
    cyc(0, 0, 0, 0, 0, 0, 0);
    chk("R5 irq one cycle", 256'(irq), 0);
    post(8'h00, 8'h01, 192'hFEED, 0, "R5 fired quiet");
    chk("R1 entry 2", wr_data, exp_entry(8'h00, 8'h01, 192'hFEED));
    db(8'd2, QID, 0);
    post(8'h09, 8'h04, 192'h1, 1, "R6 rearm");
    chk("R9 used 3", 256'(used), 3);
  endtask

  task automatic t_other_queue();
    db(8'd2, QID + 1, 0);
    db(8'd7, QID, 0);
    post(8'h01, 8'h00, 192'h2, 0, "R10 foreign or unknown doorbell");
    db(8'd4, QID + 1, 0);
    chk("R10 foreign set ci", 256'(used), 4);
  endtask

  task automatic t_overflow();
    for (int i = 0; i < 4; i++) post(8'h00, 8'h00, 192'(i), 0, "R3 fill");
    chk("R9 used full", 256'(used), 8);
    db(8'd2, QID, 0);
    ev_type = 8'h0F; cyc(1, 0, 0, 0, 0, 0, 0);
    chk("R3 drop no write", 256'(wr_en), 0);
    chk("R3 drop no irq", 256'(irq), 0);
    chk("R3 ovf", 256'(ovf), 1);
    chk("R3 status 9", 256'(status), 9);
    chk("R3 prod held", 256'(used), 8);
    cyc(0, 1, 8'd1, QID, 0, 1, 0);
    chk("R9 inc ci", 256'(used), 7);
    post(8'h0A, 8'h00, 192'h3, 1, "R4 released slot reused");
    chk("R3 ovf sticky", 256'(ovf), 1);
    chk("R9 used after reuse", 256'(used), 8);
    // arg 25 wraps to 9 = prod
    for (int s = 0; s < DEPTH; s++) cyc(0, 0, 0, 0, 0, 1, s);
    db(8'd4, QID, 25);
    chk("R9 set ci masked", 256'(used), 0);
  endtask

  task automatic t_always_disarm();
    db(8'd5, QID, 0);
    for (int i = 0; i < 3; i++) post(8'h00, 8'h00, 192'(i), 1, "R7 always");
    db(8'd3, QID, 0);
    post(8'h00, 8'h00, 192'h5, 0, "R8 disarmed");
    db(8'd2, QID, 0);
    post(8'h00, 8'h00, 192'h6, 1, "R8 R6 rearm after disarm");
  endtask

  task automatic t_same_cycle();
    release_all_sync();
    // fired: post + arm together -> no irq, then armed
    ev_type = 8'h00; cyc(1, 1, 8'd2, QID, 0, 0, 0);
    chk("R11 fired post+arm irq", 256'(irq), 0);
    chk("R11 write", 256'(wr_en), 1);
    e_prod++;
    post(8'h00, 8'h00, 192'h7, 1, "R11 armed after same-cycle arm");
    db(8'd2, QID, 0);
    cyc(1, 1, 8'd2, QID, 0, 0, 0);
    chk("R11 armed post+arm irq", 256'(irq), 1);
    e_prod++;
    post(8'h00, 8'h00, 192'h8, 1, "R11 still armed");
    cyc(1, 1, 8'd1, QID, 0, 0, 0);
    e_prod++;
    chk("R11 post+inc used", 256'(used), 4);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_entry_and_arm();
    t_other_queue();
    t_overflow();
    t_always_disarm();
    t_same_cycle();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule